// File: doc/BRIEF.md
# Single-Scan Trigger Arming Logic

This block holds, for each of a parameterised number of command queues, one single-scan arm bit. Software arms a queue by writing 1 to that queue's scan-enable control bit. Hardware disarms it when the queue is done or stopped.

The arm bit has two roles. In the level-trigger and edge-trigger single-scan modes, it decides whether a detected hardware trigger event reaches the queue state machine. In the software-trigger single-scan mode, the bit itself is the trigger. In continuous-scan mode the bit has no influence and hardware triggers pass through unchanged. In disabled mode no trigger is produced.

Three events disarm a queue:
- a command carrying the end-of-queue marker is transferred while the queue is in a single-scan mode;
- the gate closes while the queue is in level-trigger single-scan mode;
- the queue's mode enters disabled.

Software has no direct write path to the arm bit. The trigger edge and level detection and the command transfer path sit outside this block.

Top module: `sscan_arm`

## Requirements
- R1: A cycle with `arm_wr_i[q]` high and `arm_wdata_i[q]` high sets `armed_o[q]` at the next clock edge, unless a clear condition of R3, R4 or R5 is present in the same cycle.
- R2: A cycle with `arm_wr_i[q]` high and `arm_wdata_i[q]` low leaves `armed_o[q]` unchanged.
- R3: `eoq_xfer_i[q]` clears `armed_o[q]` at the next edge when the mode code of queue q is 1, 2 or 3 (software, level or edge single-scan). In code 4 (continuous) or code 0 (disabled) it has no effect.
- R4: `gate_close_i[q]` clears `armed_o[q]` at the next edge only when the mode code is 2 (level single-scan). In every other mode it has no effect.
- R5: A mode change of queue q into code 0 from any of codes 1 to 4 clears `armed_o[q]` at the next edge. Codes 5 to 7 count as disabled.
- R6: When a set request and a clear condition fall in the same cycle, the clear wins and `armed_o[q]` is 0 after the edge.
- R7: In mode code 1 (software single-scan), `trig_o[q]` equals `armed_o[q]`.
- R8: In mode codes 2 and 3 (level or edge single-scan), `trig_o[q]` is `hw_trig_i[q]` AND `armed_o[q]`. A hardware event while the queue is disarmed is ignored.
- R9: In mode code 4 (continuous), `trig_o[q]` equals `hw_trig_i[q]` regardless of `armed_o[q]`. In disabled codes (0, 5, 6, 7), `trig_o[q]` is 0.
- R10: While `rst_n` is low, every `armed_o` bit is 0.
- R11: Without a set request or clear condition, `armed_o[q]` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3*NQ | Per-queue mode code, queue q at bits [3q+2:3q] |
| arm_wr_i | input | NQ | Scan-enable control write strobe per queue |
| arm_wdata_i | input | NQ | Written value of the scan-enable bit per queue |
| eoq_xfer_i | input | NQ | Command with end-of-queue marker transferred |
| gate_close_i | input | NQ | Queue left the triggered state because the gate closed |
| hw_trig_i | input | NQ | Detected hardware trigger event |
| armed_o | output | NQ | Single-scan arm bit per queue |
| trig_o | output | NQ | Qualified trigger to the queue state machine |

## Verification
The assertions assume the following about the inputs:
- mode codes stay within 0 to 4 during normal operation;
- every strobe is a one-cycle level sampled at the clock edge;
- the surrounding logic presents the gate-closed event only as a single-cycle pulse.

The stimulus draws mode codes only from 0 to 4. It changes a queue's mode rarely, so that entry into disabled is exercised from each active mode. Strobes are driven as cycle-wide pulses set just after the falling edge, so every strobe lines up with exactly one sampling edge.

// File: rtl/sscan_pkg.sv
package sscan_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      QM_OFF  = 3'd0,
      QM_SW   = 3'd1,
      QM_LVL  = 3'd2,
      QM_EDGE = 3'd3,
      QM_CONT = 3'd4
   } qmode_e;

   function automatic logic mode_is_single(input logic [MODE_W-1:0] m);
      return (m == QM_SW) || (m == QM_LVL) || (m == QM_EDGE);
   endfunction

   function automatic logic mode_is_off(input logic [MODE_W-1:0] m);
      return !(mode_is_single(m) || (m == QM_CONT));
   endfunction

endpackage

// File: rtl/sscan_mode_watch.sv
module sscan_mode_watch
   import sscan_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   output logic              off_entry_o
);

   logic prev_off_q;
   logic now_off;

   assign now_off = mode_is_off(mode_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_off_q <= 1'b1;
      else        prev_off_q <= now_off;
   end

   assign off_entry_o = now_off && !prev_off_q;

   // R5: an entry pulse is never followed by a second entry while the mode stays off
   assert_entry_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (off_entry_o && now_off) |=> !(off_entry_o && $stable(mode_i)));

endmodule

// File: rtl/sscan_status_cell.sv
module sscan_status_cell
   import sscan_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              wr_i,
   input  logic              wdata_i,
   input  logic              eoq_i,
   input  logic              gate_i,
   input  logic              off_entry_i,
   output logic              armed_o
);

   logic set_req;
   logic clr_eoq;
   logic clr_gate;
   logic clr_any;
   logic armed_q;

   assign set_req  = wr_i && wdata_i;
   assign clr_eoq  = eoq_i && mode_is_single(mode_i);
   assign clr_gate = gate_i && (mode_i == QM_LVL);
   assign clr_any  = clr_eoq || clr_gate || off_entry_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed_q <= 1'b0;
      else if (clr_any) armed_q <= 1'b0;
      else if (set_req) armed_q <= 1'b1;
   end

   assign armed_o = armed_q;

   assert_set_takes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wdata_i && !eoq_i && !gate_i && !off_entry_i) |=> armed_o);

   assert_eoq_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (eoq_i && mode_is_single(mode_i)) |=> !armed_o);

   assert_gate_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_i && mode_i == QM_LVL) |=> !armed_o);

   assert_off_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      off_entry_i |=> !armed_o);

   assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wdata_i && off_entry_i) |=> !armed_o);

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_i && wdata_i) && !eoq_i && !gate_i && !off_entry_i) |=> $stable(armed_o));

endmodule

// File: rtl/sscan_trig_qual.sv
module sscan_trig_qual
   import sscan_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              armed_i,
   input  logic              hw_trig_i,
   output logic              trig_o
);

   logic trig_raw;

   always_comb begin
      unique case (mode_i)
         QM_SW:           trig_raw = armed_i;
         QM_LVL, QM_EDGE: trig_raw = armed_i && hw_trig_i;
         QM_CONT:         trig_raw = hw_trig_i;
         default:         trig_raw = 1'b0;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg
         logic trig_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) trig_q <= 1'b0;
            else        trig_q <= trig_raw;
         end

         assign trig_o = trig_q;

         assert_disarmed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!armed_i && (mode_i == QM_LVL || mode_i == QM_EDGE)) |=> !trig_o);
      end else begin : g_comb
         assign trig_o = trig_raw;

         assert_sw_is_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i == QM_SW) |-> (trig_o == armed_i));

         assert_disarmed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!armed_i && (mode_i == QM_LVL || mode_i == QM_EDGE)) |-> !trig_o);

         assert_off_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
            mode_is_off(mode_i) |-> !trig_o);
      end
   endgenerate

endmodule

// File: rtl/sscan_arm.sv
module sscan_arm
   import sscan_pkg::*;
#(
   parameter int NQ      = 4,
   parameter bit REG_OUT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NQ*3-1:0]    mode_i,
   input  logic [NQ-1:0]      arm_wr_i,
   input  logic [NQ-1:0]      arm_wdata_i,
   input  logic [NQ-1:0]      eoq_xfer_i,
   input  logic [NQ-1:0]      gate_close_i,
   input  logic [NQ-1:0]      hw_trig_i,
   output logic [NQ-1:0]      armed_o,
   output logic [NQ-1:0]      trig_o
);

   localparam int MW = MODE_W;

   generate
      if (NQ < 1) begin : g_bad_nq
         $error("sscan_arm: NQ must be at least 1");
      end
      if (MW * NQ != $bits(mode_i)) begin : g_bad_mw
         $error("sscan_arm: mode bus width mismatch");
      end
   endgenerate

   generate
      for (genvar q = 0; q < NQ; q++) begin : g_q
         logic [MW-1:0] mode_q;
         logic          off_entry;

         assign mode_q = mode_i[q*MW +: MW];

         sscan_mode_watch u_watch (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode_i      (mode_q),
            .off_entry_o (off_entry)
         );

         sscan_status_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode_i      (mode_q),
            .wr_i        (arm_wr_i[q]),
            .wdata_i     (arm_wdata_i[q]),
            .eoq_i       (eoq_xfer_i[q]),
            .gate_i      (gate_close_i[q]),
            .off_entry_i (off_entry),
            .armed_o     (armed_o[q])
         );

         sscan_trig_qual #(.REG_OUT(REG_OUT)) u_qual (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_i    (mode_q),
            .armed_i   (armed_o[q]),
            .hw_trig_i (hw_trig_i[q]),
            .trig_o    (trig_o[q])
         );

         assert_wr0_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (arm_wr_i[q] && !arm_wdata_i[q] && !armed_o[q]) |=> !armed_o[q]);
      end
   endgenerate

   always_comb begin
      if (!rst_n) assert_reset_clear_R10: assert (armed_o == '0);
   end

endmodule

// File: tb/sscan_arm_bench.sv
`timescale 1ns/1ps
module sscan_arm_bench;

   localparam int NQ = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NQ*3-1:0] mode_i = '0;
   logic [NQ-1:0]   arm_wr_i = '0;
   logic [NQ-1:0]   arm_wdata_i = '0;
   logic [NQ-1:0]   eoq_xfer_i = '0;
   logic [NQ-1:0]   gate_close_i = '0;
   logic [NQ-1:0]   hw_trig_i = '0;
   logic [NQ-1:0]   armed_o;
   logic [NQ-1:0]   trig_o;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit done = 0;
   string tag = "R10";

   int m_arm  [NQ];
   int m_prev [NQ];

   sscan_arm #(.NQ(NQ)) u_sscan_arm (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .arm_wr_i(arm_wr_i),
      .arm_wdata_i(arm_wdata_i), .eoq_xfer_i(eoq_xfer_i),
      .gate_close_i(gate_close_i), .hw_trig_i(hw_trig_i),
      .armed_o(armed_o), .trig_o(trig_o));

   always #4 clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000 && !done) begin
         bad++;
         total++;
         $display("FAIL watchdog: run hung, actual=%0d expected<=200000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic int mode_of(int q);
      return int'(mode_i[q*3 +: 3]);
   endfunction

   function automatic bit off_code(int m);
      return (m == 0) || (m > 4);
   endfunction

   function automatic int exp_trig(int q);
      int m = mode_of(q);
      if (m == 1) return m_arm[q];
      if (m == 2 || m == 3) return m_arm[q] & int'(hw_trig_i[q]);
      if (m == 4) return int'(hw_trig_i[q]);
      return 0;
   endfunction

   task automatic check(string t, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", t, what, act, exp, cycles);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      for (int q = 0; q < NQ; q++) begin
         int m = mode_of(q);
         if (!rst_n) begin
            m_arm[q]  = 0;
            m_prev[q] = 0;
         end else begin
            bit clr = 0;
            if (eoq_xfer_i[q] && (m >= 1 && m <= 3)) clr = 1;
            if (gate_close_i[q] && m == 2) clr = 1;
            if (off_code(m) && !off_code(m_prev[q])) clr = 1;
            if (clr) m_arm[q] = 0;
            else if (arm_wr_i[q] && arm_wdata_i[q]) m_arm[q] = 1;
            m_prev[q] = m;
         end
      end
      for (int q = 0; q < NQ; q++) begin
         check(tag, $sformatf("armed[%0d]", q), int'(armed_o[q]), m_arm[q]);
         check(tag, $sformatf("trig[%0d]", q), int'(trig_o[q]), exp_trig(q));
      end
   endtask

   task automatic quiet();
      arm_wr_i = '0; arm_wdata_i = '0; eoq_xfer_i = '0; gate_close_i = '0;
   endtask

   task automatic set_mode(int q, int m);
      mode_i[q*3 +: 3] = 3'(m);
   endtask

   task automatic arm(int q, bit v);
      arm_wr_i[q] = 1'b1; arm_wdata_i[q] = v;
   endtask

   initial begin
      for (int q = 0; q < NQ; q++) begin m_arm[q] = 0; m_prev[q] = 0; end
      tag = "R10";
      arm_wr_i = '1; arm_wdata_i = '1;
      repeat (3) tick();
      quiet();
      tick();
      rst_n = 1'b1;
      tick();

      tag = "R7";
      set_mode(0, 1); set_mode(1, 2); set_mode(2, 4); set_mode(3, 3);
      tick();
      tag = "R1"; arm(0, 1); tick(); quiet(); tick();
      tag = "R2"; arm(1, 0); tick(); quiet(); tick();
      tag = "R3"; eoq_xfer_i[0] = 1'b1; tick(); quiet(); tick();
      tag = "R9"; arm(2, 1); tick(); quiet();
      hw_trig_i[2] = 1'b1; tick(); hw_trig_i[2] = 1'b0; tick();
      tag = "R3"; eoq_xfer_i[2] = 1'b1; tick(); quiet(); tick();
      tag = "R4"; arm(1, 1); arm(3, 1); tick(); quiet();
      gate_close_i = 4'b1010; tick(); quiet(); tick();
      tag = "R8"; hw_trig_i[3] = 1'b1; tick(); hw_trig_i = '0; hw_trig_i[1] = 1'b1; tick();
      hw_trig_i = '0;
      tag = "R5"; set_mode(3, 0); tick(); tick();
      tag = "R9"; hw_trig_i[3] = 1'b1; arm(3, 1); tick(); quiet(); tick(); hw_trig_i = '0;
      tag = "R6"; arm(0, 1); eoq_xfer_i[0] = 1'b1; tick(); quiet(); tick();
      tag = "R6"; set_mode(2, 0); arm(2, 1); tick(); quiet(); tick();
      tag = "R11"; tick(); tick();

      for (int i = 0; i < 4000; i++) begin
         quiet();
         for (int q = 0; q < NQ; q++) begin
            if ($urandom_range(15) == 0) set_mode(q, $urandom_range(4));
            arm_wr_i[q]     = ($urandom_range(5) == 0);
            arm_wdata_i[q]  = $urandom_range(1);
            eoq_xfer_i[q]   = ($urandom_range(9) == 0);
            gate_close_i[q] = ($urandom_range(9) == 0);
            hw_trig_i[q]    = $urandom_range(1);
         end
         tick();
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule